// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler

This block derives single-cycle clock-enable strobes for three bus domains from one system clock. A fast bus strobe is produced by dividing the system clock by a power of two chosen by a 4-bit code. Two slow bus strobes are each produced by dividing the fast bus strobe again, by a power of two chosen by a 3-bit code. None of the outputs is a clock. Each is an enable that downstream logic, clocked by the system clock, uses to qualify its updates.

The fast-bus code is not linear. Codes 0 to 7 all mean divide by 1. Codes 8 to 15 select 2, 4, 8, 16, 64, 128, 256 and 512, so a ratio of 32 cannot be selected. Each slow-bus code uses the upper half of the same scale: codes 0 to 3 mean divide by 1, and codes 4 to 7 select 2, 4, 8 and 16. A combinational read port returns the shift amount (log2 of the ratio) implied by any of the three codes, so software can compute bus frequencies.

Each divider is a two-state machine. DIV_BYPASS means the ratio is 1, and the strobe follows its input tick. DIV_COUNT means the ratio is above 1, and the strobe fires only when the down-counter is at zero. The only transition happens at a period boundary, which is an input tick that arrives while the counter is zero. At that boundary the divider samples its code. It moves to DIV_BYPASS if the shift is 0, and otherwise moves to DIV_COUNT and reloads the counter with 2^shift − 1. Reset places every divider in DIV_BYPASS with its counter at zero.

Top module: `bus_strobe_divider`

## Requirements
- R1: In the first cycle after reset is released, all three strobes are high, whatever the codes. The codes present then are adopted at that cycle's clock edge.
- R2: With a fixed fast code, `hs_en` is high in cycle k after reset release exactly when k mod 2^S = 0. S is 0 for codes 0–7, code−7 for codes 8–11, and code−6 for codes 12–15.
- R3: A slow code maps to shift T. T is 0 for codes 0–3 and code−3 for codes 4–7.
- R4: Each slow strobe counts fast strobes rather than system cycles. With fixed codes it is high in cycle k exactly when k mod 2^(S+T) = 0.
- R5: A slow strobe is never high in a cycle where `hs_en` is low.
- R6: With a divide-by-1 code in effect, the strobe is high on every cycle.
- R7: A code change is adopted only at the next period boundary. The strobe that ends the current period arrives on the old schedule, and the new ratio applies from that strobe onward. Consecutive fast strobes are always a power of two apart, and never more than 512 cycles apart.
- R8: `rd_shift` returns the shift for `hs_code` when `rd_sel`=0, for `ls0_code` when `rd_sel`=1, and for `ls1_code` when `rd_sel`=2. It returns 0 when `rd_sel`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_code | input | 4 | Fast-bus ratio code |
| ls0_code | input | 3 | First slow-bus ratio code |
| ls1_code | input | 3 | Second slow-bus ratio code |
| rd_sel | input | 2 | Read-port code selector |
| hs_en | output | 1 | Fast-bus enable strobe |
| ls0_en | output | 1 | First slow-bus enable strobe |
| ls1_en | output | 1 | Second slow-bus enable strobe |
| rd_shift | output | 4 | Shift amount implied by the selected code |

## Verification
The hardest case to reach is a code change that lands in the middle of a period. The divider must keep the old schedule until its counter expires, and must then switch to the new ratio. The stimulus changes the code one cycle after a strobe, both from a longer ratio to divide-by-1 and the reverse. It does this once on the fast divider and once on a slow divider. It then checks cycle by cycle that the old boundary still fires and that the new spacing follows it. Full sweeps over every code, each started from reset, confirm the composed slow-bus period arithmetically.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int HS_CODE_W = 4;
    localparam int LS_CODE_W = 3;
    localparam int SHIFT_W   = 4;
    localparam int MAX_SHIFT = 9;
    localparam int N_LS      = 2;

    typedef enum logic {
        DIV_BYPASS,
        DIV_COUNT
    } div_state_e;

    // Fast code: upper half of the scale skips a ratio of 32.
    function automatic logic [SHIFT_W-1:0] hs_shift_of(input logic [HS_CODE_W-1:0] code);
        if (!code[3])      return 4'd0;
        else if (!code[2]) return {2'b00, code[1:0]} + 4'd1;
        else               return {2'b00, code[1:0]} + 4'd6;
    endfunction

    function automatic logic [SHIFT_W-1:0] ls_shift_of(input logic [LS_CODE_W-1:0] code);
        if (!code[2]) return 4'd0;
        else          return {2'b00, code[1:0]} + 4'd1;
    endfunction

endpackage

// File: rtl/strobe_div.sv
module strobe_div
    import bsd_pkg::*;
#(
    parameter int SH_W    = SHIFT_W,
    parameter int MAX_SH  = MAX_SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [SH_W-1:0] shift_i,
    output logic            strobe_o
);

    localparam int CNT_W = (MAX_SH < 1) ? 1 : MAX_SH;

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   span_m1;
    logic             boundary;

    assign boundary = tick_i && (cnt_q == '0);
    assign span_m1  = ({{CNT_W{1'b0}}, 1'b1} << shift_i) - 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_BYPASS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: the ratio is re-sampled only at a period boundary
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (boundary) begin
            state_d = (shift_i == '0) ? DIV_BYPASS : DIV_COUNT;
            cnt_d   = span_m1[CNT_W-1:0];
        end else if (tick_i) begin
            cnt_d   = cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            DIV_BYPASS: strobe_o = tick_i;
            DIV_COUNT:  strobe_o = boundary;
            default:    strobe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/shift_reader.sv
module shift_reader
    import bsd_pkg::*;
(
    input  logic [HS_CODE_W-1:0] hs_code,
    input  logic [LS_CODE_W-1:0] ls0_code,
    input  logic [LS_CODE_W-1:0] ls1_code,
    input  logic [1:0]           rd_sel,
    output logic [SHIFT_W-1:0]   rd_shift
);

    always_comb begin
        unique case (rd_sel)
            2'd0:    rd_shift = hs_shift_of(hs_code);
            2'd1:    rd_shift = ls_shift_of(ls0_code);
            2'd2:    rd_shift = ls_shift_of(ls1_code);
            default: rd_shift = '0;
        endcase
    end

endmodule

// File: rtl/bus_strobe_divider.sv
module bus_strobe_divider
    import bsd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HS_CODE_W-1:0] hs_code,
    input  logic [LS_CODE_W-1:0] ls0_code,
    input  logic [LS_CODE_W-1:0] ls1_code,
    input  logic [1:0]           rd_sel,
    output logic                 hs_en,
    output logic                 ls0_en,
    output logic                 ls1_en,
    output logic [SHIFT_W-1:0]   rd_shift
);

    logic [LS_CODE_W-1:0] ls_code_a [N_LS];
    logic [N_LS-1:0]      ls_en_a;

    assign ls_code_a[0] = ls0_code;
    assign ls_code_a[1] = ls1_code;

    strobe_div #(.SH_W(SHIFT_W), .MAX_SH(MAX_SHIFT)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (1'b1),
        .shift_i (hs_shift_of(hs_code)),
        .strobe_o(hs_en)
    );

    // slow dividers count fast-bus strobes
    for (genvar i = 0; i < N_LS; i++) begin : g_ls
        strobe_div #(.SH_W(SHIFT_W), .MAX_SH(4)) u_ls (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (hs_en),
            .shift_i (ls_shift_of(ls_code_a[i])),
            .strobe_o(ls_en_a[i])
        );
    end

    assign ls0_en = ls_en_a[0];
    assign ls1_en = ls_en_a[1];

    shift_reader u_rd (
        .hs_code (hs_code),
        .ls0_code(ls0_code),
        .ls1_code(ls1_code),
        .rd_sel  (rd_sel),
        .rd_shift(rd_shift)
    );

endmodule

// File: rtl/bus_strobe_divider_chk.sv
module bus_strobe_divider_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] hs_code,
    input logic [1:0] rd_sel,
    input logic       hs_en,
    input logic       ls0_en,
    input logic       ls1_en,
    input logic [3:0] rd_shift
);

    logic [9:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= '0;
        else if (hs_en)            gap_q <= 10'd1;
        else if (gap_q != 10'h3FF) gap_q <= gap_q + 10'd1;
    end

    a_r5_ls0_inside_hs: assert property (@(posedge clk) disable iff (!rst_n)
        ls0_en |-> hs_en);

    a_r5_ls1_inside_hs: assert property (@(posedge clk) disable iff (!rst_n)
        ls1_en |-> hs_en);

    a_r6_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hs_en) && !$past(hs_code[3])) |-> hs_en);

    a_r7_period_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && gap_q != 10'd0) |-> ($countones(gap_q) == 1 && gap_q <= 10'd512));

    a_r8_hs_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd0) |-> (rd_shift <= 4'd9 && rd_shift != 4'd5));

endmodule

bind bus_strobe_divider bus_strobe_divider_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_code (hs_code),
    .rd_sel  (rd_sel),
    .hs_en   (hs_en),
    .ls0_en  (ls0_en),
    .ls1_en  (ls1_en),
    .rd_shift(rd_shift)
);

// File: tb/bus_strobe_divider_test.sv
module bus_strobe_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hs_code = '0;
    logic [2:0] ls0_code = '0;
    logic [2:0] ls1_code = '0;
    logic [1:0] rd_sel = '0;
    logic       hs_en, ls0_en, ls1_en;
    logic [3:0] rd_shift;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bus_strobe_divider uut (
        .clk(clk), .rst_n(rst_n), .hs_code(hs_code), .ls0_code(ls0_code),
        .ls1_code(ls1_code), .rd_sel(rd_sel), .hs_en(hs_en), .ls0_en(ls0_en),
        .ls1_en(ls1_en), .rd_shift(rd_shift)
    );

    function automatic int hs_sh(input int c);
        if (c < 8)  return 0;
        if (c < 12) return c - 7;
        return c - 6;
    endfunction

    function automatic int ls_sh(input int c);
        return (c < 4) ? 0 : c - 3;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Static configuration from reset; cycle k counted from release.
    task automatic run_static(input int hc, input int a, input int b);
        int s, t0, t1, tm, len;
        hs_code = 4'(hc); ls0_code = 3'(a); ls1_code = 3'(b);
        s = hs_sh(hc); t0 = ls_sh(a); t1 = ls_sh(b);
        tm = (t0 > t1) ? t0 : t1;
        len = 2 * (1 << (s + tm));
        if (len > 2048) len = 2048;
        if (len < 8) len = 8;
        do_reset();
        for (int k = 0; k < len; k++) begin
            #1;
            if (k == 0) begin
                check("R1 hs_en", int'(hs_en), 1);
                check("R1 ls0_en", int'(ls0_en), 1);
                check("R1 ls1_en", int'(ls1_en), 1);
            end else begin
                check((s == 0) ? "R6 hs_en" : "R2 hs_en", int'(hs_en), int'((k % (1 << s)) == 0));
                check("R3/R4 ls0_en", int'(ls0_en), int'((k % (1 << (s + t0))) == 0));
                check("R3/R4 ls1_en", int'(ls1_en), int'((k % (1 << (s + t1))) == 0));
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: read port over every code
        for (int c = 0; c < 16; c++) begin
            hs_code = 4'(c); rd_sel = 2'd0; #1;
            check("R8 hs shift", int'(rd_shift), hs_sh(c));
        end
        for (int c = 0; c < 8; c++) begin
            ls0_code = 3'(c); ls1_code = 3'(7 - c);
            rd_sel = 2'd1; #1; check("R8 ls0 shift", int'(rd_shift), ls_sh(c));
            rd_sel = 2'd2; #1; check("R8 ls1 shift", int'(rd_shift), ls_sh(7 - c));
            rd_sel = 2'd3; #1; check("R8 unused sel", int'(rd_shift), 0);
        end
        rd_sel = 2'd0;

        // R2, R4, R6: every fast code
        for (int c = 0; c < 16; c++) run_static(c, c % 8, 7 - (c % 8));
        // R3, R4: every slow code under a /2 fast bus
        for (int a = 0; a < 8; a++) run_static(8, a, a ^ 3);

        // R7: fast divider changes mid-period
        begin
            int pat[16] = '{1,0,0,0,1,1,1,0,0,0,0,0,0,0,1,0};
            hs_code = 4'd9; ls0_code = 3'd0; ls1_code = 3'd0;
            do_reset();
            for (int k = 0; k < 16; k++) begin
                #1;
                check("R7 hs_en", int'(hs_en), pat[k]);
                check("R7 ls0_en", int'(ls0_en), pat[k]);
                if (k == 1) hs_code = 4'd0;
                if (k == 6) hs_code = 4'd10;
                @(negedge clk);
            end
        end

        // R7: slow divider changes mid-period
        begin
            int pat[8] = '{1,0,0,0,1,1,1,1};
            hs_code = 4'd0; ls0_code = 3'd5; ls1_code = 3'd4;
            do_reset();
            for (int k = 0; k < 8; k++) begin
                #1;
                check("R7 ls0_en", int'(ls0_en), pat[k]);
                check("R7 ls1_en", int'(ls1_en), int'((k % 2) == 0));
                if (k == 1) ls0_code = 3'd0;
                @(negedge clk);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule